// File: doc/BRIEF.md
# Interrupt Arbitration and Vectoring Unit

This unit makes the interrupt decisions of an 8-bit processor core. At each instruction boundary the core pulses `instr_end`. The unit then picks one winner from three sources: a bus request, a pending non-maskable request, or the level-sensitive maskable request. It holds the two interrupt enable bits and the current vectoring mode, and it updates them from one-cycle strobes sent by the instruction decoder.

A non-maskable request is caught on the falling edge of its pin and held until it is serviced. It always goes to a fixed restart address. A maskable request that is accepted starts an acknowledge bus cycle, which includes automatic wait cycles, and captures the byte that the responding device places on the data bus. From that byte the unit forms one of three results:
- a fixed restart address;
- a restart slot decoded from the byte;
- a table address made from the page register and the byte.

An external sequencer uses this result to push the program counter and, for the table case, to fetch the two target bytes.

Top module: `cpu_irq_unit`

## Requirements
- R1: After reset both enable bits are 0, the mode is 0, `iack_n` is 1 and no vector is offered.
- R2: A boundary carrying `ev_ei` sets both enable bits. A boundary carrying `ev_di` clears both. A maskable request is never accepted at a boundary that carries `ev_ei` or `ev_di`.
- R3: A maskable request is accepted only when all of these hold at a boundary: `int_n` is 0, enable bit 1 is set, `busrq_n` is 1 and no non-maskable request is pending. Acceptance clears both enable bits and lowers `iack_n` in the next cycle.
- R4: The acknowledge cycle keeps `iack_n` low for 3+ACK_WAITS cycles. `ack_wait` is high in its 3rd and 4th cycles (ACK_WAITS=2). `ack_data` is captured in its last cycle, and `vec_valid` is high for exactly the cycle after it.
- R5: A falling edge on `nmi_n` is latched. It is taken at the next boundary whatever the enable bits are, and it yields `vec_valid`=1, `vec_nmi`=1 and `vec_addr`=0x0066 in the next cycle. A pin held low does not trigger a second time.
- R6: Taking a non-maskable request clears enable bit 1 and copies the prior bit 1 into bit 2. `ev_retn` copies bit 2 into bit 1. `ev_reti` leaves both bits unchanged.
- R7: At a boundary the priority is `busrq_n` low first, then the pending non-maskable request, then the maskable one. A bus request produces a one-cycle `bus_yield` pulse, starts no acknowledge and keeps a pending non-maskable request pending.
- R8: In mode 1 the vector is 0x0038, whatever byte is on `ack_data`.
- R9: In mode 0 the vector is `ack_data[5:3]` times 8. A restart opcode has the form 11ttt111, and all bits other than 5:3 are ignored.
- R10: In mode 2 `vec_table` is 1 and `vec_addr` is {`i_reg`, `ack_data[7:1]`, 0}.
- R11: `ev_im` with `im_sel` equal to 0, 1 or 2 selects that mode. `im_sel`=3 leaves the mode unchanged.
- R12: `ev_ld_air` loads `pv_flag` with enable bit 2 as it was in that cycle. The new value is visible in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| int_n | input | 1 | Maskable request, active low, level |
| nmi_n | input | 1 | Non-maskable request, active low, edge |
| busrq_n | input | 1 | Bus request, active low |
| instr_end | input | 1 | Last cycle of an instruction |
| ev_ei | input | 1 | Enable-interrupts instruction strobe |
| ev_di | input | 1 | Disable-interrupts instruction strobe |
| ev_retn | input | 1 | Return-from-non-maskable strobe |
| ev_reti | input | 1 | Return-from-maskable strobe |
| ev_im | input | 1 | Mode-select instruction strobe |
| im_sel | input | 2 | Mode number carried by `ev_im` |
| ev_ld_air | input | 1 | Load-accumulator-from-page/refresh strobe |
| i_reg | input | DATA_W | Vector page register |
| ack_data | input | DATA_W | Data bus byte during acknowledge |
| iack_n | output | 1 | Acknowledge cycle active, low |
| ack_wait | output | 1 | Automatic wait cycle of the acknowledge |
| bus_yield | output | 1 | Boundary given to the bus request |
| vec_valid | output | 1 | Vector result valid (one cycle) |
| vec_nmi | output | 1 | Result belongs to a non-maskable take |
| vec_table | output | 1 | `vec_addr` is a table address |
| vec_addr | output | ADDR_W | Restart or table address |
| iff1 | output | 1 | Enable bit 1 |
| iff2 | output | 1 | Enable bit 2 |
| im_mode | output | 2 | Current vectoring mode |
| pv_flag | output | 1 | Enable bit 2 copy for the flag register |

## Verification
The checker assumes a few things about the core and the decoder:
- `instr_end` never arrives while `iack_n` is low;
- `ev_ei` and `ev_di` never appear together;
- a non-maskable take follows a boundary that carried no enable-bit strobe, which its save-and-restore property relies on.

The directed stimulus drives these inputs on falling clock edges. It waits for every acknowledge to finish before it issues the next boundary, and it issues each strobe alone. The non-maskable pin is released and given an idle cycle before each new edge, so that every edge is a clean one.

// File: rtl/irq_pkg.sv
package irq_pkg;

   typedef enum logic [1:0] {
      IM_ZERO = 2'd0,
      IM_ONE  = 2'd1,
      IM_TWO  = 2'd2
   } im_mode_e;

   localparam int unsigned ACK_BASE_CYCLES = 3;
   localparam int unsigned ACK_FIRST_WAIT  = 2;

   function automatic logic im_sel_legal(input logic [1:0] sel);
      return sel != 2'd3;
   endfunction

endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic nmi_n,
   input  logic clear,
   output logic pending
);
   logic nmi_q;
   logic fall;

   assign fall = nmi_q & ~nmi_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         nmi_q   <= 1'b1;
         pending <= 1'b0;
      end else begin
         nmi_q   <= nmi_n;
         pending <= (pending & ~clear) | fall;
      end
   end
endmodule

// File: rtl/irq_enable_regs.sv
module irq_enable_regs
   import irq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ev_ei,
   input  logic       ev_di,
   input  logic       ev_retn,
   input  logic       ev_reti,
   input  logic       ev_im,
   input  logic [1:0] im_sel,
   input  logic       ev_ld_air,
   input  logic       take_nmi,
   input  logic       take_int,
   output logic       iff1,
   output logic       iff2,
   output im_mode_e   im_mode,
   output logic       pv_flag
);
   logic ins1, ins2;
   logic nxt1, nxt2;

   // effect of the completing instruction first
   always_comb begin
      ins1 = iff1;
      ins2 = iff2;
      if (ev_ei) begin
         ins1 = 1'b1;
         ins2 = 1'b1;
      end else if (ev_di) begin
         ins1 = 1'b0;
         ins2 = 1'b0;
      end else if (ev_retn) begin
         ins1 = iff2;
      end else if (ev_reti) begin
         ins1 = iff1;
         ins2 = iff2;
      end
   end

   // then the effect of the interrupt taken at that boundary
   always_comb begin
      nxt1 = ins1;
      nxt2 = ins2;
      if (take_int) begin
         nxt1 = 1'b0;
         nxt2 = 1'b0;
      end else if (take_nmi) begin
         nxt1 = 1'b0;
         nxt2 = ins1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         iff1    <= 1'b0;
         iff2    <= 1'b0;
         im_mode <= IM_ZERO;
         pv_flag <= 1'b0;
      end else begin
         iff1 <= nxt1;
         iff2 <= nxt2;
         if (ev_im && im_sel_legal(im_sel))
            im_mode <= im_mode_e'(im_sel);
         if (ev_ld_air)
            pv_flag <= iff2;
      end
   end
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned ACK_WAITS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] bus_byte,
   output logic              active,
   output logic              wait_cyc,
   output logic              done,
   output logic [DATA_W-1:0] captured
);
   localparam int unsigned ACK_LEN = irq_pkg::ACK_BASE_CYCLES + ACK_WAITS;
   localparam int unsigned CNT_W   = $clog2(ACK_LEN + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(ACK_LEN - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active   <= 1'b0;
         done     <= 1'b0;
         cnt      <= '0;
         captured <= '0;
      end else begin
         done <= 1'b0;
         if (start && !active) begin
            active <= 1'b1;
            cnt    <= '0;
         end else if (active) begin
            if (cnt == LAST) begin
               active   <= 1'b0;
               done     <= 1'b1;
               captured <= bus_byte;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   generate
      if (ACK_WAITS > 0) begin : g_waits
         localparam logic [CNT_W-1:0] W_LO = CNT_W'(irq_pkg::ACK_FIRST_WAIT);
         localparam logic [CNT_W-1:0] W_HI = CNT_W'(irq_pkg::ACK_FIRST_WAIT + ACK_WAITS);
         assign wait_cyc = active && (cnt >= W_LO) && (cnt < W_HI);
      end else begin : g_no_waits
         assign wait_cyc = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/irq_vector_gen.sv
module irq_vector_gen
   import irq_pkg::*;
#(
   parameter int unsigned       DATA_W  = 8,
   parameter int unsigned       ADDR_W  = 16,
   parameter logic [ADDR_W-1:0] NMI_VEC = 16'h0066,
   parameter logic [ADDR_W-1:0] IM1_VEC = 16'h0038
) (
   input  logic              is_nmi,
   input  im_mode_e          mode,
   input  logic [DATA_W-1:0] dev_byte,
   input  logic [DATA_W-1:0] page,
   output logic [ADDR_W-1:0] addr,
   output logic              table_ref
);
   localparam int unsigned SLOT_SHIFT = 3;

   always_comb begin
      table_ref = 1'b0;
      addr      = '0;
      if (is_nmi) begin
         addr = NMI_VEC;
      end else begin
         unique case (mode)
            IM_ONE: addr = IM1_VEC;
            IM_TWO: begin
               addr      = {page, dev_byte[DATA_W-1:1], 1'b0};
               table_ref = 1'b1;
            end
            default: addr = ADDR_W'({dev_byte[5:3], {SLOT_SHIFT{1'b0}}});
         endcase
      end
   end
endmodule

// File: rtl/cpu_irq_unit.sv
module cpu_irq_unit
   import irq_pkg::*;
#(
   parameter int unsigned       DATA_W    = 8,
   parameter int unsigned       ADDR_W    = 16,
   parameter int unsigned       ACK_WAITS = 2,
   parameter logic [ADDR_W-1:0] NMI_VEC   = 16'h0066,
   parameter logic [ADDR_W-1:0] IM1_VEC   = 16'h0038
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              int_n,
   input  logic              nmi_n,
   input  logic              busrq_n,
   input  logic              instr_end,
   input  logic              ev_ei,
   input  logic              ev_di,
   input  logic              ev_retn,
   input  logic              ev_reti,
   input  logic              ev_im,
   input  logic [1:0]        im_sel,
   input  logic              ev_ld_air,
   input  logic [DATA_W-1:0] i_reg,
   input  logic [DATA_W-1:0] ack_data,
   output logic              iack_n,
   output logic              ack_wait,
   output logic              bus_yield,
   output logic              vec_valid,
   output logic              vec_nmi,
   output logic              vec_table,
   output logic [ADDR_W-1:0] vec_addr,
   output logic              iff1,
   output logic              iff2,
   output logic [1:0]        im_mode,
   output logic              pv_flag
);
   generate
      if (ADDR_W != 2 * DATA_W) begin : g_bad_width
         $error("cpu_irq_unit: ADDR_W must be twice DATA_W");
      end
      if (DATA_W < 6) begin : g_bad_data
         $error("cpu_irq_unit: DATA_W must hold a restart opcode");
      end
   endgenerate

   logic     nmi_pend;
   logic     ack_busy;
   logic     ack_done;
   logic     boundary;
   logic     take_nmi;
   logic     take_int;
   logic     nmi_take_q;
   im_mode_e mode_q;
   logic [DATA_W-1:0] cap_byte;

   assign boundary = instr_end & ~ack_busy;
   assign take_nmi = boundary & busrq_n & nmi_pend;
   assign take_int = boundary & busrq_n & ~nmi_pend & ~int_n
                   & iff1 & ~ev_ei & ~ev_di;

   irq_nmi_latch u_nmi (
      .clk     (clk),
      .rst_n   (rst_n),
      .nmi_n   (nmi_n),
      .clear   (take_nmi),
      .pending (nmi_pend)
   );

   irq_enable_regs u_en (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev_ei     (ev_ei),
      .ev_di     (ev_di),
      .ev_retn   (ev_retn),
      .ev_reti   (ev_reti),
      .ev_im     (ev_im),
      .im_sel    (im_sel),
      .ev_ld_air (ev_ld_air),
      .take_nmi  (take_nmi),
      .take_int  (take_int),
      .iff1      (iff1),
      .iff2      (iff2),
      .im_mode   (mode_q),
      .pv_flag   (pv_flag)
   );

   irq_ack_seq #(.DATA_W(DATA_W), .ACK_WAITS(ACK_WAITS)) u_ack (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (take_int),
      .bus_byte (ack_data),
      .active   (ack_busy),
      .wait_cyc (ack_wait),
      .done     (ack_done),
      .captured (cap_byte)
   );

   irq_vector_gen #(
      .DATA_W (DATA_W), .ADDR_W (ADDR_W),
      .NMI_VEC(NMI_VEC), .IM1_VEC(IM1_VEC)
   ) u_vec (
      .is_nmi    (nmi_take_q),
      .mode      (mode_q),
      .dev_byte  (cap_byte),
      .page      (i_reg),
      .addr      (vec_addr),
      .table_ref (vec_table)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         nmi_take_q <= 1'b0;
         bus_yield  <= 1'b0;
      end else begin
         nmi_take_q <= take_nmi;
         bus_yield  <= boundary & ~busrq_n;
      end
   end

   assign iack_n    = ~ack_busy;
   assign vec_valid = nmi_take_q | ack_done;
   assign vec_nmi   = nmi_take_q;
   assign im_mode   = mode_q;
endmodule

// File: rtl/cpu_irq_unit_chk.sv
module cpu_irq_unit_chk #(
   parameter int unsigned       ADDR_W    = 16,
   parameter int unsigned       ACK_WAITS = 2,
   parameter logic [ADDR_W-1:0] NMI_VEC   = 16'h0066
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busrq_n,
   input logic              instr_end,
   input logic              ev_ei,
   input logic              ev_di,
   input logic              ev_ld_air,
   input logic              iack_n,
   input logic              bus_yield,
   input logic              vec_valid,
   input logic              vec_nmi,
   input logic              vec_table,
   input logic [ADDR_W-1:0] vec_addr,
   input logic              iff1,
   input logic              iff2,
   input logic              pv_flag,
   input logic              ev_retn
);
   localparam int unsigned ACK_LEN = 3 + ACK_WAITS;

   logic [7:0] low_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         low_cnt <= '0;
      else if (iack_n)
         low_cnt <= '0;
      else if (low_cnt != 8'hFF)
         low_cnt <= low_cnt + 1'b1;
   end

   assert_ack_disables_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(iack_n) |-> (!iff1 && !iff2));

   assert_ack_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(iack_n) |-> (low_cnt == 8'(ACK_LEN)));

   assert_di_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ev_di) && !$past(ev_ei)) |-> (!iff1 && !iff2));

   assert_nmi_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_valid && vec_nmi) |-> (vec_addr == NMI_VEC && !vec_table));

   assert_nmi_save_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_nmi && !$past(ev_ei) && !$past(ev_di) && !$past(ev_retn))
         |-> (!iff1 && iff2 == $past(iff1)));

   assert_bus_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(instr_end && !busrq_n && iack_n) |-> (bus_yield && iack_n && !vec_valid));

   assert_table_even_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_valid && vec_table) |-> !vec_addr[0]);

   assert_pv_copy_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ev_ld_air) |-> (pv_flag == $past(iff2)));
endmodule

bind cpu_irq_unit cpu_irq_unit_chk #(
   .ADDR_W(ADDR_W), .ACK_WAITS(ACK_WAITS), .NMI_VEC(NMI_VEC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busrq_n   (busrq_n),
   .instr_end (instr_end),
   .ev_ei     (ev_ei),
   .ev_di     (ev_di),
   .ev_ld_air (ev_ld_air),
   .iack_n    (iack_n),
   .bus_yield (bus_yield),
   .vec_valid (vec_valid),
   .vec_nmi   (vec_nmi),
   .vec_table (vec_table),
   .vec_addr  (vec_addr),
   .iff1      (iff1),
   .iff2      (iff2),
   .pv_flag   (pv_flag),
   .ev_retn   (ev_retn)
);

// File: tb/test_cpu_irq_unit.sv
`timescale 1ns/1ps
module test_cpu_irq_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        int_n = 1'b1, nmi_n = 1'b1, busrq_n = 1'b1, instr_end = 1'b0;
   logic        ev_ei = 0, ev_di = 0, ev_retn = 0, ev_reti = 0, ev_im = 0, ev_ld_air = 0;
   logic [1:0]  im_sel = 2'd0;
   logic [7:0]  i_reg = 8'h00, ack_data = 8'h00;
   logic        iack_n, ack_wait, bus_yield, vec_valid, vec_nmi, vec_table;
   logic [15:0] vec_addr;
   logic        iff1, iff2, pv_flag;
   logic [1:0]  im_mode;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   cpu_irq_unit i_cpu_irq_unit (
      .clk(clk), .rst_n(rst_n), .int_n(int_n), .nmi_n(nmi_n), .busrq_n(busrq_n),
      .instr_end(instr_end), .ev_ei(ev_ei), .ev_di(ev_di), .ev_retn(ev_retn),
      .ev_reti(ev_reti), .ev_im(ev_im), .im_sel(im_sel), .ev_ld_air(ev_ld_air),
      .i_reg(i_reg), .ack_data(ack_data), .iack_n(iack_n), .ack_wait(ack_wait),
      .bus_yield(bus_yield), .vec_valid(vec_valid), .vec_nmi(vec_nmi),
      .vec_table(vec_table), .vec_addr(vec_addr), .iff1(iff1), .iff2(iff2),
      .im_mode(im_mode), .pv_flag(pv_flag)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic boundary(input logic ei, input logic di, input logic retn,
                           input logic reti, input logic ldair);
      instr_end = 1'b1; ev_ei = ei; ev_di = di; ev_retn = retn;
      ev_reti = reti; ev_ld_air = ldair;
      @(negedge clk);
      instr_end = 1'b0; ev_ei = 0; ev_di = 0; ev_retn = 0; ev_reti = 0; ev_ld_air = 0;
   endtask

   task automatic plain();
      boundary(0, 0, 0, 0, 0);
   endtask

   task automatic set_mode(input logic [1:0] m);
      instr_end = 1'b1; ev_im = 1'b1; im_sel = m;
      @(negedge clk);
      instr_end = 1'b0; ev_im = 1'b0;
   endtask

   task automatic run_ack(input string tag, input logic [15:0] exp_addr, input logic exp_tbl);
      for (int k = 0; k < 5; k++) begin
         chk({tag, " R4 iack low"}, iack_n, 0);
         chk({tag, " R4 wait phase"}, ack_wait, (k == 2 || k == 3));
         chk({tag, " R4 no early vector"}, vec_valid, 0);
         @(negedge clk);
      end
      chk({tag, " R4 vec_valid"}, vec_valid, 1);
      chk({tag, " iack released"}, iack_n, 1);
      chk({tag, " vec_nmi"}, vec_nmi, 0);
      chk({tag, " addr"}, vec_addr, exp_addr);
      chk({tag, " table"}, vec_table, exp_tbl);
      @(negedge clk);
      chk({tag, " R4 single pulse"}, vec_valid, 0);
   endtask

   task automatic t_reset();
      chk("R1 iff1", iff1, 0);
      chk("R1 iff2", iff2, 0);
      chk("R1 mode", im_mode, 0);
      chk("R1 iack_n", iack_n, 1);
      chk("R1 vec_valid", vec_valid, 0);
   endtask

   task automatic t_modes();
      set_mode(2'd1); chk("R11 mode1", im_mode, 1);
      set_mode(2'd2); chk("R11 mode2", im_mode, 2);
      set_mode(2'd3); chk("R11 sel3 ignored", im_mode, 2);
      set_mode(2'd0); chk("R11 mode0", im_mode, 0);
   endtask

   task automatic t_ei_di();
      int_n = 1'b0;
      boundary(1, 0, 0, 0, 0);
      chk("R2 ei iff1", iff1, 1);
      chk("R2 ei iff2", iff2, 1);
      chk("R2 no take at ei boundary", iack_n, 1);
      boundary(0, 1, 0, 0, 0);
      chk("R2 di iff1", iff1, 0);
      chk("R2 di iff2", iff2, 0);
      chk("R2 no take at di boundary", iack_n, 1);
      int_n = 1'b1;
   endtask

   task automatic t_masked();
      int_n = 1'b0;
      plain();
      chk("R3 masked no ack", iack_n, 1);
      chk("R3 masked no vector", vec_valid, 0);
      int_n = 1'b1;
   endtask

   task automatic take_int(input logic [1:0] m, input logic [7:0] byte_v,
                           input string tag, input logic [15:0] exp_addr, input logic tbl);
      set_mode(m);
      boundary(1, 0, 0, 0, 0);
      ack_data = byte_v;
      int_n = 1'b0;
      plain();
      int_n = 1'b1;
      chk({tag, " R3 iff1 cleared"}, iff1, 0);
      chk({tag, " R3 iff2 cleared"}, iff2, 0);
      run_ack(tag, exp_addr, tbl);
   endtask

   task automatic t_nmi();
      boundary(1, 0, 0, 0, 0);
      nmi_n = 1'b0;
      @(negedge clk);
      plain();
      chk("R5 nmi vec_valid", vec_valid, 1);
      chk("R5 nmi flag", vec_nmi, 1);
      chk("R5 nmi addr", vec_addr, 16'h0066);
      chk("R6 nmi iff1", iff1, 0);
      chk("R6 nmi iff2 saved", iff2, 1);
      plain();
      chk("R5 held low no retrigger", vec_valid, 0);
      boundary(0, 0, 1, 0, 0);
      chk("R6 retn restores iff1", iff1, 1);
      nmi_n = 1'b1;
      @(negedge clk);
      boundary(0, 1, 0, 0, 0);
      nmi_n = 1'b0;
      @(negedge clk);
      plain();
      chk("R5 taken while disabled", vec_nmi, 1);
      chk("R6 iff2 saved zero", iff2, 0);
      nmi_n = 1'b1;
      @(negedge clk);
      boundary(1, 0, 0, 0, 0);
      boundary(0, 0, 0, 1, 0);
      chk("R6 reti keeps iff1", iff1, 1);
      chk("R6 reti keeps iff2", iff2, 1);
      boundary(0, 1, 0, 0, 0);
   endtask

   task automatic t_priority();
      set_mode(2'd1);
      boundary(1, 0, 0, 0, 0);
      nmi_n = 1'b0;
      @(negedge clk);
      int_n = 1'b0; busrq_n = 1'b0;
      plain();
      chk("R7 bus yield", bus_yield, 1);
      chk("R7 no vector under busrq", vec_valid, 0);
      chk("R7 no ack under busrq", iack_n, 1);
      busrq_n = 1'b1;
      plain();
      chk("R7 nmi kept and wins", vec_nmi, 1);
      chk("R7 int loses to nmi", iack_n, 1);
      chk("R7 yield one pulse", bus_yield, 0);
      nmi_n = 1'b1;
      boundary(1, 0, 0, 0, 0);
      busrq_n = 1'b0;
      plain();
      chk("R7 int held off by busrq", iack_n, 1);
      busrq_n = 1'b1;
      ack_data = 8'h00;
      plain();
      int_n = 1'b1;
      run_ack("R7 int after bus", 16'h0038, 0);
   endtask

   task automatic t_pv();
      boundary(1, 0, 0, 0, 0);
      boundary(0, 0, 0, 0, 1);
      chk("R12 pv set", pv_flag, 1);
      boundary(0, 1, 0, 0, 0);
      boundary(0, 0, 0, 0, 1);
      chk("R12 pv clear", pv_flag, 0);
   endtask

   initial begin
      #2_000_000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_modes();
      t_ei_di();
      t_masked();
      take_int(2'd1, 8'hA5, "R8 mode1", 16'h0038, 0);
      take_int(2'd0, 8'hEF, "R9 mode0 rst", 16'h0028, 0);
      take_int(2'd0, 8'h2A, "R9 mode0 other bits", 16'h0028, 0);
      i_reg = 8'h80;
      take_int(2'd2, 8'h35, "R10 mode2", 16'h8034, 1);
      t_nmi();
      t_priority();
      t_pv();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule